// File: doc/BRIEF.md
# Quad Digital Potentiometer Register Controller

This block holds the control registers of four 256-position digital potentiometers. Each channel has one volatile 8-bit wiper counter and four 8-bit data registers. The data registers stand in for nonvolatile cells. The wiper code sets the tap position: 0x00 is the tap closest to the low terminal and 0xFF is the tap closest to the high terminal. The four wiper codes leave the block on one flat output bus, which drives the analog tap decoders.

An upstream decoder supplies commands that are already decoded. There is one command per cycle, given by an operation code, a channel, a register index and a data byte. The wiper can be loaded in four ways: directly from the host, in parallel from one of its channel's data registers, by a single up or down step, and from data register 0 when reset is released. Any command that changes a data register starts a long programming period, timed by a cycle counter. During that period a write-in-progress flag is high. Only one such write can be pending at a time. While the period runs, wiper commands and data register reads are still served.

Top module: `dpot_quad_ctrl`

## Requirements
- R1: While rst_ni is low, every wiper output, wip_o, err_o and rd_valid_o are 0. After reset, data register r of channel c holds 16*c + r + 1.
- R2: On the first clock edge after rst_ni rises, each wiper loads data register 0 of its own channel. A command presented at that edge is ignored.
- R3: cmd_op_i codes are: 0 none, 1 write wiper, 2 read data register, 3 write data register, 4 data register to wiper, 5 wiper to data register, 6 increment, 7 decrement. A write-wiper command loads cmd_data_i into the wiper of channel cmd_ch_i and leaves the other wipers unchanged. Channel c appears on wiper_o[8c+7:8c].
- R4: Increment and decrement change the addressed wiper by one. Increment at 0xFF and decrement at 0x00 leave it unchanged.
- R5: A read presents the addressed data register on rd_data_o, with rd_valid_o high for exactly the one cycle after the command edge.
- R6: An accepted data register write raises wip_o after the command edge. wip_o stays high for WRITE_CYCLES cycles, and the new value is committed on the edge where wip_o falls.
- R7: A read issued while wip_o is 1 returns the value held before the pending write.
- R8: A data register write or wiper-to-register command issued while wip_o is 1 is rejected. It raises err_o for one cycle and changes no data register.
- R9: Wiper load, step and register-to-wiper commands are carried out while wip_o is 1.
- R10: A register-to-wiper command copies the addressed data register of the channel into its wiper on the command edge.
- R11: A wiper-to-register command stores the wiper value from the command cycle, using the same busy timing as R6. Later wiper changes do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code (see R3) |
| cmd_ch_i | input | 2 | Channel index |
| cmd_reg_i | input | 2 | Data register index |
| cmd_data_i | input | 8 | Data byte for writes |
| wiper_o | output | 32 | Four wiper codes, channel c at bits 8c+7:8c |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid pulse |
| wip_o | output | 1 | Nonvolatile write in progress |
| err_o | output | 1 | Rejected-write pulse |

## Verification
The assertions check the following on every cycle:
- the wiper loads from register 0 on the cycle after reset;
- steps have unit size and saturate at both ends;
- data registers change only on a commit;
- a new write never starts while one is pending;
- the error, read-valid and busy-rise pulses each follow the command that causes them.

Only the bench scenarios show the following:
- the exact length of the busy window;
- that a read during the window returns the old contents;
- that a rejected byte never reaches storage;
- that a wiper-to-register copy keeps the wiper value from the command cycle even after the wiper moves.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DR    = 3'd2,
    OP_WR_DR    = 3'd3,
    OP_DR2W     = 3'd4,
    OP_W2DR     = 3'd5,
    OP_INC      = 3'd6,
    OP_DEC      = 3'd7
  } dpot_op_e;

  // storage image restored at power-up
  function automatic logic [7:0] nv_default(int unsigned ch, int unsigned rg);
    return 8'((ch * 16) + rg + 1);
  endfunction

endpackage

// File: rtl/dpot_wiper.sv
module dpot_wiper #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [DW-1:0] init_val_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] wiper_o
);

  localparam logic [DW-1:0] MAX_CODE = '1;

  logic [DW-1:0] wiper_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wiper_q <= '0;
    else if (init_i)                      wiper_q <= init_val_i;
    else if (ld_i)                        wiper_q <= ld_val_i;
    else if (inc_i && wiper_q != MAX_CODE) wiper_q <= wiper_q + 1'b1;
    else if (dec_i && wiper_q != '0)       wiper_q <= wiper_q - 1'b1;
  end

  assign wiper_o = wiper_q;

  // R2
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> wiper_o == $past(init_val_i));

  // R4
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !init_i && !ld_i && wiper_o == MAX_CODE) |=> wiper_o == MAX_CODE);

  // R4
  dec_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !init_i && !ld_i && wiper_o == '0) |=> wiper_o == '0);

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !init_i && !ld_i && wiper_o != MAX_CODE) |=> wiper_o == $past(wiper_o) + 1'b1);

endmodule

// File: rtl/dpot_nv_bank.sv
module dpot_nv_bank #(
  parameter int DW     = 8,
  parameter int NUM_DR = 4,
  parameter int CH_IDX = 0,
  localparam int RG_W  = $clog2(NUM_DR)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [RG_W-1:0]      commit_reg_i,
  input  logic [DW-1:0]        commit_data_i,
  output logic [NUM_DR*DW-1:0] dr_o
);

  logic [NUM_DR*DW-1:0] dr_q;

  for (genvar r = 0; r < NUM_DR; r++) begin : g_reg
    localparam logic [DW-1:0] INIT = DW'(dpot_pkg::nv_default(CH_IDX, r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  dr_q[r*DW +: DW] <= INIT;
      else if (commit_i && commit_reg_i == RG_W'(r)) dr_q[r*DW +: DW] <= commit_data_i;
    end
  end

  assign dr_o = dr_q;

  // R8
  dr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(dr_o));

endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int DW           = 8,
  parameter int CH_W         = 2,
  parameter int RG_W         = 2,
  parameter int WRITE_CYCLES = 500_000,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic [RG_W-1:0] start_reg_i,
  input  logic [DW-1:0]   start_data_i,
  output logic            busy_o,
  output logic            commit_o,
  output logic [CH_W-1:0] commit_ch_o,
  output logic [RG_W-1:0] commit_reg_o,
  output logic [DW-1:0]   commit_data_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [RG_W-1:0]  reg_q;
  logic [DW-1:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ch_q   <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WRITE_CYCLES - 1);
      ch_q   <= start_ch_i;
      reg_q  <= start_reg_i;
      data_q <= start_data_i;
    end
  end

  assign busy_o        = busy_q;
  assign commit_o      = busy_q && (cnt_q == '0);
  assign commit_ch_o   = ch_q;
  assign commit_reg_o  = reg_q;
  assign commit_data_o = data_q;

  // R8
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);

  // R6
  commit_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);

endmodule

// File: rtl/dpot_quad_ctrl.sv
module dpot_quad_ctrl #(
  parameter int NUM_CH       = 4,
  parameter int NUM_DR       = 4,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 500_000,
  localparam int CH_W        = $clog2(NUM_CH),
  localparam int RG_W        = $clog2(NUM_DR)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [CH_W-1:0]      cmd_ch_i,
  input  logic [RG_W-1:0]      cmd_reg_i,
  input  logic [DW-1:0]        cmd_data_i,
  output logic [NUM_CH*DW-1:0] wiper_o,
  output logic [DW-1:0]        rd_data_o,
  output logic                 rd_valid_o,
  output logic                 wip_o,
  output logic                 err_o
);
  import dpot_pkg::*;

  dpot_op_e        op;
  logic            init_q;
  logic            act;
  logic            nv_wr, nv_start, nv_reject;
  logic            busy, commit;
  logic [CH_W-1:0] commit_ch;
  logic [RG_W-1:0] commit_reg;
  logic [DW-1:0]   commit_data;
  logic [DW-1:0]   sel_dr, sel_wiper, start_data;
  logic [DW-1:0]   rd_data_q;
  logic            rd_valid_q, err_q;

  logic [NUM_DR*DW-1:0] dr_flat [NUM_CH];

  assign op        = dpot_op_e'(cmd_op_i);
  assign act       = cmd_valid_i && !init_q;
  assign nv_wr     = act && (op == OP_WR_DR || op == OP_W2DR);
  assign nv_start  = nv_wr && !busy;
  assign nv_reject = nv_wr && busy;

  assign sel_dr     = dr_flat[cmd_ch_i][cmd_reg_i*DW +: DW];
  assign sel_wiper  = wiper_o[cmd_ch_i*DW +: DW];
  assign start_data = (op == OP_W2DR) ? sel_wiper : cmd_data_i;

  // power-up reload pending for one cycle after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  dpot_nv_timer #(
    .DW(DW), .CH_W(CH_W), .RG_W(RG_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (nv_start),
    .start_ch_i    (cmd_ch_i),
    .start_reg_i   (cmd_reg_i),
    .start_data_i  (start_data),
    .busy_o        (busy),
    .commit_o      (commit),
    .commit_ch_o   (commit_ch),
    .commit_reg_o  (commit_reg),
    .commit_data_o (commit_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = act && (cmd_ch_i == CH_W'(c));

    dpot_nv_bank #(.DW(DW), .NUM_DR(NUM_DR), .CH_IDX(c)) u_bank (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .commit_i      (commit && (commit_ch == CH_W'(c))),
      .commit_reg_i  (commit_reg),
      .commit_data_i (commit_data),
      .dr_o          (dr_flat[c])
    );

    dpot_wiper #(.DW(DW)) u_wiper (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_i     (init_q),
      .init_val_i (dr_flat[c][DW-1:0]),
      .ld_i       (hit && (op == OP_WR_WIPER || op == OP_DR2W)),
      .ld_val_i   ((op == OP_DR2W) ? sel_dr : cmd_data_i),
      .inc_i      (hit && op == OP_INC),
      .dec_i      (hit && op == OP_DEC),
      .wiper_o    (wiper_o[c*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= act && (op == OP_RD_DR);
      err_q      <= nv_reject;
      if (act && op == OP_RD_DR) rd_data_q <= sel_dr;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign wip_o      = busy;
  assign err_o      = err_q;

  // R8
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i && wip_o && (cmd_op_i == 3'd3 || cmd_op_i == 3'd5)));

  // R6
  wip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cmd_valid_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd5)));

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i && cmd_op_i == 3'd2));

endmodule

// File: tb/dpot_quad_ctrl_bench.sv
module dpot_quad_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_ch = '0;
  logic [1:0]  cmd_reg = '0;
  logic [7:0]  cmd_data = '0;
  logic [31:0] wiper;
  logic [7:0]  rd_data;
  logic        rd_valid, wip, err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_start;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpot_quad_ctrl #(.WRITE_CYCLES(WCYC)) u_dpot_quad_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ch_i(cmd_ch), .cmd_reg_i(cmd_reg), .cmd_data_i(cmd_data),
    .wiper_o(wiper), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .wip_o(wip), .err_o(err)
  );

  function automatic logic [7:0] nv_init(int c, int r);
    return 8'(16 * c + r + 1);
  endfunction

  function automatic logic [7:0] wp(int c);
    return wiper[c*8 +: 8];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, outputs of the command edge are visible on return
  task automatic issue(logic [2:0] op, int c, int r, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = 2'(c); cmd_reg = 2'(r); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 wipers in reset", wiper, 32'h0);
    check("R1 wip in reset", wip, 0);
    check("R1 err in reset", err, 0);
    check("R1 rd_valid in reset", rd_valid, 0);
    rst_ni = 1'b1;
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_ch = 2'd0; cmd_data = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    for (int c = 0; c < 4; c++) check("R2 wiper reload from reg 0", wp(c), nv_init(c, 0));
  endtask

  task automatic t_read;
    issue(3'd2, 2, 3, 8'h00);
    check("R5 rd_valid pulse", rd_valid, 1);
    check("R1 default contents", rd_data, nv_init(2, 3));
    @(negedge clk);
    check("R5 rd_valid one cycle", rd_valid, 0);
  endtask

  task automatic t_direct;
    issue(3'd1, 2, 0, 8'h5A);
    check("R3 direct write", wp(2), 8'h5A);
    check("R3 other channel 1", wp(1), nv_init(1, 0));
    check("R3 other channel 3", wp(3), nv_init(3, 0));
  endtask

  task automatic t_step;
    issue(3'd1, 1, 0, 8'hFE);
    issue(3'd6, 1, 0, 8'h00);
    check("R4 inc", wp(1), 8'hFF);
    issue(3'd6, 1, 0, 8'h00);
    check("R4 inc saturates", wp(1), 8'hFF);
    issue(3'd1, 1, 0, 8'h01);
    issue(3'd7, 1, 0, 8'h00);
    check("R4 dec", wp(1), 8'h00);
    issue(3'd7, 1, 0, 8'h00);
    check("R4 dec floors", wp(1), 8'h00);
    issue(3'd6, 1, 0, 8'h00);
    check("R4 inc from zero", wp(1), 8'h01);
  endtask

  task automatic t_nv_write;
    issue(3'd3, 1, 2, 8'hA5);
    t_start = cyc;
    check("R6 wip raised", wip, 1);
    issue(3'd2, 1, 2, 8'h00);
    check("R7 read during busy old value", rd_data, nv_init(1, 2));
    issue(3'd3, 0, 0, 8'h77);
    check("R8 err pulse", err, 1);
    @(negedge clk);
    check("R8 err one cycle", err, 0);
    issue(3'd6, 3, 0, 8'h00);
    check("R9 inc while busy", wp(3), nv_init(3, 0) + 8'h1);
    issue(3'd4, 1, 2, 8'h00);
    check("R9 copy while busy gets old", wp(1), nv_init(1, 2));
    wait_cyc(t_start + WCYC - 1);
    check("R6 wip still high at last cycle", wip, 1);
    @(negedge clk);
    check("R6 wip low after window", wip, 0);
    issue(3'd2, 1, 2, 8'h00);
    check("R6 committed value", rd_data, 8'hA5);
    issue(3'd2, 0, 0, 8'h00);
    check("R8 rejected not stored", rd_data, nv_init(0, 0));
  endtask

  task automatic t_xfer;
    issue(3'd4, 3, 3, 8'h00);
    check("R10 reg to wiper", wp(3), nv_init(3, 3));
    issue(3'd1, 0, 0, 8'h33);
    issue(3'd5, 0, 1, 8'h00);
    t_start = cyc;
    check("R11 wip raised", wip, 1);
    issue(3'd1, 0, 0, 8'h99);
    issue(3'd5, 2, 0, 8'h00);
    check("R8 wiper-to-reg rejected while busy", err, 1);
    wait_cyc(t_start + WCYC);
    check("R11 wip low after window", wip, 0);
    issue(3'd2, 0, 1, 8'h00);
    check("R11 stored command-time wiper", rd_data, 8'h33);
    issue(3'd2, 2, 0, 8'h00);
    check("R8 rejected copy not stored", rd_data, nv_init(2, 0));
    issue(3'd3, 3, 1, 8'h42);
    check("R6 write accepted once idle", wip, 1);
    check("R6 no err once idle", err, 0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_direct();
    t_step();
    t_nv_write();
    t_xfer();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule